// File: doc/BRIEF.md
# Registered Saturating Signed Adder

This block adds two N-bit two's-complement operands and stores the sum in an output register on the rising clock edge. If the true sum falls outside the N-bit signed range, the stored value clamps to the nearest limit instead of wrapping. Overflow is found without a widened adder. The low N-1 bits of both operands are added as unsigned values. The carry out of that addition is the carry into the sign position. The two operand sign bits and that carry then decide both the sign of the result and whether clamping occurs.

A static select input turns on symmetric range mode. In that mode the most negative code, -2^(N-1), is never produced. Any result that would be that code is raised by one to -(2^(N-1)-1), so the output range is symmetric about zero. This applies whether the code came from an exact sum or from negative clamping. A registered flag marks every cycle in which the stored value differs from the plain wrapped sum.

The block has no states. Its behaviour is a single register stage: in reset it loads zero, and otherwise it loads the clamped sum.

Top module: `sat_adder_reg`

## Requirements
- R1: When the true sum of a_in and b_in fits in N signed bits, and the symmetric rule does not apply, q_out equals that sum one rising edge after the operands are presented.
- R2: A true sum above 2^(N-1)-1 makes q_out equal 2^(N-1)-1, the pattern 0 followed by N-1 ones.
- R3: With sym_en at 0, a true sum below -2^(N-1) makes q_out equal -2^(N-1), the pattern 1 followed by N-1 zeros.
- R4: With sym_en at 0, operands whose sign bits (bit N-1) differ never clamp: q_out is the wrapped sum and sat_out is 0.
- R5: With sym_en at 1, q_out is never -2^(N-1). Where that value would result, from an exact sum or from negative clamping, q_out is -2^(N-1)+1 instead.
- R6: sat_out is 1 exactly when the registered q_out differs from (a_in + b_in) mod 2^N for the operands captured at the same edge.
- R7: When rst is high at a rising edge, q_out and sat_out become 0 at that edge, whatever the operands are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | N | First operand, two's complement |
| b_in | input | N | Second operand, two's complement |
| sym_en | input | 1 | 1 selects the range symmetric about zero |
| q_out | output | N | Registered clamped sum |
| sat_out | output | 1 | Registered flag: stored value differs from the wrapped sum |

## Verification
The bench builds the block with N=8. At that width every one of the 65,536 operand pairs can be applied in each mode, one pair per clock, so every clamp, non-clamp and symmetric-floor case is covered exhaustively. This includes the lone pairs that land exactly on -128. A synchronous reset applied in the middle of the run, while large operands are held on the inputs, covers the clearing rule.

// File: rtl/sat_adder_pkg.sv
package sat_adder_pkg;

    // Kind of limit applied to the raw sum
    typedef enum logic [1:0] {
        CLAMP_NONE = 2'd0,
        CLAMP_POS  = 2'd1,
        CLAMP_NEG  = 2'd2
    } clamp_kind_e;

endpackage

// File: rtl/sat_low_adder.sv
// Unsigned ripple add of the operand bits below the sign position.
module sat_low_adder #(
    parameter int W = 7
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    output logic [W-1:0] sum,
    output logic         carry_out
);
    logic [W:0] chain;

    assign chain[0] = 1'b0;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign sum[i]     = x[i] ^ y[i] ^ chain[i];
        assign chain[i+1] = (x[i] & y[i]) | (chain[i] & (x[i] ^ y[i]));
    end

    assign carry_out = chain[W];
endmodule

// File: rtl/sat_select.sv
// Derives the sign, the clamp decision and the value to load.
module sat_select
    import sat_adder_pkg::*;
#(
    parameter int N = 8
) (
    input  logic           sign_a,
    input  logic           sign_b,
    input  logic           carry_in_sign,
    input  logic [N-2:0]   low_sum,
    input  logic           sym_en,
    output logic [N-1:0]   next_q,
    output logic           next_sat
);
    localparam int LW = N - 1;
    localparam logic [N-1:0] FLOOR_CODE = {1'b1, {LW{1'b0}}};
    localparam logic [N-1:0] SYM_FLOOR  = FLOOR_CODE + 1'b1;

    logic        res_sign;
    clamp_kind_e kind;
    logic [N-1:0] base;
    logic        bump;

    always_comb begin
        res_sign = (sign_a & sign_b) | ((sign_a ^ sign_b) & ~carry_in_sign);
        if (~sign_a & ~sign_b & carry_in_sign)
            kind = CLAMP_POS;
        else if (sign_a & sign_b & ~carry_in_sign)
            kind = CLAMP_NEG;
        else
            kind = CLAMP_NONE;
    end

    always_comb begin
        unique case (kind)
            CLAMP_POS,
            CLAMP_NEG:  base = {res_sign, {LW{~sign_a}}};
            default:    base = {res_sign, low_sum};
        endcase
    end

    always_comb begin
        bump     = sym_en && (base == FLOOR_CODE);
        next_q   = bump ? SYM_FLOOR : base;
        next_sat = (kind != CLAMP_NONE) || bump;
    end
endmodule

// File: rtl/sat_adder_reg.sv
module sat_adder_reg #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] a_in,
    input  logic [N-1:0] b_in,
    input  logic         sym_en,
    output logic [N-1:0] q_out,
    output logic         sat_out
);
    localparam int LW = N - 1;

    logic [LW-1:0] low_sum;
    logic          carry_sign;
    logic [N-1:0]  next_q;
    logic          next_sat;

    sat_low_adder #(.W(LW)) u_low (
        .x         (a_in[LW-1:0]),
        .y         (b_in[LW-1:0]),
        .sum       (low_sum),
        .carry_out (carry_sign)
    );

    sat_select #(.N(N)) u_sel (
        .sign_a        (a_in[N-1]),
        .sign_b        (b_in[N-1]),
        .carry_in_sign (carry_sign),
        .low_sum       (low_sum),
        .sym_en        (sym_en),
        .next_q        (next_q),
        .next_sat      (next_sat)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            q_out   <= '0;
            sat_out <= 1'b0;
        end else begin
            q_out   <= next_q;
            sat_out <= next_sat;
        end
    end
endmodule

// File: rtl/sat_adder_chk.sv
module sat_adder_chk #(
    parameter int N = 8
) (
    input logic         clk,
    input logic         rst,
    input logic [N-1:0] a_in,
    input logic [N-1:0] b_in,
    input logic         sym_en,
    input logic [N-1:0] q_out,
    input logic         sat_out
);
    localparam logic [N-1:0] MIN_CODE = {1'b1, {(N-1){1'b0}}};

    logic         past_ok;
    logic [N-1:0] wrap_sum;

    assign wrap_sum = a_in + b_in;

    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    // R1
    plain_sum_chk: assert property (@(posedge clk) disable iff (rst)
        (past_ok && !sat_out) |-> (q_out == $past(wrap_sum)));

    // R2
    pos_clamp_chk: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(!a_in[N-1] && !b_in[N-1])) |-> !q_out[N-1]);

    // R3
    neg_clamp_chk: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(a_in[N-1] && b_in[N-1])) |-> q_out[N-1]);

    // R4
    opp_sign_chk: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past((a_in[N-1] != b_in[N-1]) && !sym_en)) |-> !sat_out);

    // R5
    sym_floor_chk: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(sym_en)) |-> (q_out != MIN_CODE));

    // R6
    flag_match_chk: assert property (@(posedge clk) disable iff (rst)
        past_ok |-> (sat_out == (q_out != $past(wrap_sum))));

    // R7
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (q_out == '0 && !sat_out));
endmodule

bind sat_adder_reg sat_adder_chk #(.N(N)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .a_in    (a_in),
    .b_in    (b_in),
    .sym_en  (sym_en),
    .q_out   (q_out),
    .sat_out (sat_out)
);

// File: tb/tb_sat_adder_reg.sv
`timescale 1ns/1ps
module tb_sat_adder_reg;
    localparam int N    = 8;
    localparam int FULL = 1 << N;
    localparam int MAXV = (1 << (N-1)) - 1;
    localparam int MINV = -(1 << (N-1));

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] a_in = '0;
    logic [N-1:0] b_in = '0;
    logic         sym_en = 1'b0;
    logic [N-1:0] q_out;
    logic         sat_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    sat_adder_reg #(.N(N)) dut (
        .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in),
        .sym_en(sym_en), .q_out(q_out), .sat_out(sat_out)
    );

    function automatic int to_signed(input int u);
        return (u > MAXV) ? u - FULL : u;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic apply_reset(input int av, input int bv);
        @(negedge clk);
        rst  = 1'b1;
        a_in = av[N-1:0];
        b_in = bv[N-1:0];
        @(posedge clk); #5;
        check("R7 q", int'(q_out), 0);
        check("R7 sat", int'(sat_out), 0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic run_vec(input int au, input int bu, input bit sym);
        int s, ex, exp_q, wrap;
        string tag;
        @(negedge clk);
        a_in   = au[N-1:0];
        b_in   = bu[N-1:0];
        sym_en = sym;
        s = to_signed(au) + to_signed(bu);
        if (s > MAXV)      begin ex = MAXV; tag = "R2"; end
        else if (s < MINV) begin ex = MINV; tag = sym ? "R5" : "R3"; end
        else begin
            ex = s;
            if (sym && s == MINV) tag = "R5";
            else if (!sym && (au[N-1] != bu[N-1])) tag = "R4";
            else tag = "R1";
        end
        if (sym && ex == MINV) ex = MINV + 1;
        exp_q = (ex + FULL) % FULL;
        wrap  = (au + bu) % FULL;
        @(posedge clk); #5;
        check(tag, int'(q_out), exp_q);
        check((tag == "R4") ? "R4 sat" : "R6 sat", int'(sat_out),
              (exp_q != wrap) ? 1 : 0);
    endtask

    initial begin
        apply_reset(MAXV, MAXV);
        for (int m = 0; m < 2; m++) begin
            for (int a = 0; a < FULL; a++) begin
                for (int b = 0; b < FULL; b++) begin
                    run_vec(a, b, m[0]);
                end
            end
            apply_reset(FULL - 1, 1 << (N-1));
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule